// File: doc/BRIEF.md
# Configurable Logic-Array Macrocell Register

This block is the storage and output stage of one cell in a programmable logic array. It takes the combinational sum that the array produces for the cell and registers it. Static configuration inputs set how the cell behaves. The register works either as a data-capture flop or as a toggle flop. Its clock is one of four clock sources, and each cell chooses independently whether to act on the rising or the falling edge of that clock. An asynchronous initialisation can be driven from one of two control terms, as either a set or a clear, or it can be switched off.

The cell's output buffer is modelled as a data value plus an enable, and the level seen at the pad comes back in on a separate input. The enable comes from one of four control terms, or it is held permanently on or permanently off. A chip-wide active-low float input can override the enable when its own configuration bit allows this. The interconnect receives two feedback signals. One is the register value, taken before the buffer, and it stays valid while the cell is buried. The other is the pad value, taken after the buffer, so that a pad whose output is disabled can serve as an input.

Configuration is meant to be loaded while power-on reset is held and then left unchanged.

Top module: `mcell_top`

## Requirements
- R1: While `por_n` is 0 the register holds 0 at once, whatever the clocks, control terms and configuration are doing. This takes priority over set, clear and clock edges.
- R2: With `cfg_t_mode`=0, each active clock edge loads `sum_in` into the register.
- R3: With `cfg_t_mode`=1, each active clock edge inverts the register when `sum_in` is 1 and leaves it unchanged when `sum_in` is 0.
- R4: `cfg_clk_sel` gives the clock number. Clock 0 is always `ext_clk[0]`. Clock n (n = 1 to 3) is `int_clk[n-1]` when `cfg_clk_int[n-1]`=1, and `ext_clk[n]` otherwise. Edges on clock sources that are not selected have no effect.
- R5: `cfg_clk_fall`=0 makes the rising edge of the selected clock the active edge. `cfg_clk_fall`=1 makes it the falling edge.
- R6: `cfg_init_mode` sets the initialisation: 2'b01 is set, 2'b10 is clear, and 2'b00 or 2'b11 is off. `cfg_init_ct` chooses between `ct_init[0]` and `ct_init[1]`. While the chosen term is 1 and initialisation is on, the register is forced asynchronously to 1 (set) or 0 (clear), and clock edges are ignored. The term that is not chosen has no effect.
- R7: `cfg_oe_sel` values 0 to 3 take the output enable from `ct_oe[0]` to `ct_oe[3]`. Value 4 keeps the output always enabled. Values 5 to 7 keep it always disabled.
- R8: When `cfg_gts_en`=1 and `gts_n`=0, `pad_oe` is 0 whatever `cfg_oe_sel` selects. When `cfg_gts_en`=0, `gts_n` is ignored.
- R9: `pad_out` and `fb_reg` always carry the register value, also while the output is disabled. `fb_pad` always carries `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_clk | input | 4 | Clock sources driven from pins |
| int_clk | input | 3 | Clock sources from array logic, for clocks 1 to 3 |
| cfg_clk_int | input | 3 | Per clock 1 to 3: 1 takes the logic source |
| cfg_clk_sel | input | 2 | Number of the selected clock |
| cfg_clk_fall | input | 1 | 1 makes the falling edge the active edge |
| cfg_t_mode | input | 1 | 0 for data capture, 1 for toggle |
| cfg_init_mode | input | 2 | Initialisation mode: off, set or clear |
| cfg_init_ct | input | 1 | Chooses the initialisation control term |
| ct_init | input | 2 | Initialisation control terms |
| cfg_oe_sel | input | 3 | Output-enable source |
| ct_oe | input | 4 | Output-enable control terms |
| cfg_gts_en | input | 1 | Lets `gts_n` take effect |
| gts_n | input | 1 | Global float, active low |
| sum_in | input | 1 | Combinational sum from the array |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Output buffer enable |
| fb_reg | output | 1 | Register feedback to the interconnect |
| fb_pad | output | 1 | Pad feedback to the interconnect |

## Verification
The bench sweeps every combination of clock number, logic-or-pin source, edge polarity and register mode. In each step it pulses a random subset of all seven clock sources. A step whose selected source is not in the subset shows whether stray clocks are ignored. Sampling between the rising and the falling half of each pulse shows whether the correct edge polarity is used. Random sums in toggle mode tell hold apart from invert. In the initialisation runs both control terms are asserted at random while clocks arrive, which separates the chosen term from the unchosen one and checks that the forced value beats the clock. The output-enable runs pair every source code with random control terms and global float levels, both with and without the float enable, and keep the pad level independent of the register so that the two feedback paths stay distinguishable.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    INIT_OFF     = 2'b00,
    INIT_SET     = 2'b01,
    INIT_CLR     = 2'b10,
    INIT_OFF_ALT = 2'b11
  } init_mode_e;

  // next register value on an active edge
  function automatic logic f_next_q(input logic t_mode, input logic q, input logic d);
    return t_mode ? (q ^ d) : d;
  endfunction

  // {set, clr} requested by the chosen control term
  function automatic logic [1:0] f_init_drive(input init_mode_e mode, input logic term);
    logic [1:0] r;
    case (mode)
      INIT_SET: r = {term, 1'b0};
      INIT_CLR: r = {1'b0, term};
      default:  r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int NCLK = 4,
  localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic [NCLK-1:0] ext_clk_i,
  input  logic [NCLK-2:0] int_clk_i,
  input  logic [NCLK-2:0] use_int_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            fall_i,
  output logic            clk_o
);
  logic [NCLK-1:0] src;
  logic            picked;

  assign src[0] = ext_clk_i[0];

  generate
    for (genvar i = 1; i < NCLK; i++) begin : g_src
      assign src[i] = use_int_i[i-1] ? int_clk_i[i-1] : ext_clk_i[i];
    end
  endgenerate

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NCLK; i++)
      if (sel_i == SELW'(i)) picked = src[i];
  end

  assign clk_o = picked ^ fall_i;

endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
(
  input  logic clk_i,
  input  logic por_n_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic t_mode_i,
  input  logic d_i,
  output logic q_o
);
  logic async_clr;
  logic async_set;
  logic q;
  logic init_hit;  // an async force occurred since the last clean edge

  assign async_clr = ~por_n_i | clr_i;
  assign async_set = por_n_i & set_i & ~clr_i;

  always_ff @(posedge clk_i or posedge async_clr or posedge async_set) begin
    if (async_clr)      q <= 1'b0;
    else if (async_set) q <= 1'b1;
    else                q <= f_next_q(t_mode_i, q, d_i);
  end

  always_ff @(posedge clk_i or posedge async_clr or posedge async_set) begin
    if (async_clr || async_set) init_hit <= 1'b1;
    else                        init_hit <= 1'b0;
  end

  assign q_o = q;

  assert_dmode_capture_R2: assert property (@(posedge clk_i) disable iff (async_clr || async_set)
    !t_mode_i |=> (init_hit || q == $past(d_i)));

  assert_tmode_toggle_R3: assert property (@(posedge clk_i) disable iff (async_clr || async_set)
    t_mode_i |=> (init_hit || q == ($past(q) ^ $past(d_i))));

  assert_set_holds_one_R6: assert property (@(posedge clk_i) disable iff (async_clr)
    async_set |-> q);

  assert_clear_holds_zero_R1: assert property (@(posedge clk_i) disable iff (async_set)
    async_clr |-> !q);

endmodule

// File: rtl/mcell_oe.sv
module mcell_oe #(
  parameter int NOE = 4,
  localparam int OE_SELW = $clog2(NOE + 2)
) (
  input  logic [NOE-1:0]     ct_i,
  input  logic [OE_SELW-1:0] sel_i,
  input  logic               gts_en_i,
  input  logic               gts_n_i,
  output logic               oe_o
);
  logic oe_raw;
  logic gts_force;

  always_comb begin
    oe_raw = (sel_i == OE_SELW'(NOE));  // constant-on code
    for (int i = 0; i < NOE; i++)
      if (sel_i == OE_SELW'(i)) oe_raw = ct_i[i];
  end

  assign gts_force = gts_en_i & ~gts_n_i;
  assign oe_o      = oe_raw & ~gts_force;

endmodule

// File: rtl/mcell_top.sv
module mcell_top
  import mcell_pkg::*;
#(
  parameter int NCLK  = 4,
  parameter int NOE   = 4,
  parameter int NINIT = 2,
  localparam int CLK_SELW  = $clog2(NCLK),
  localparam int OE_SELW   = $clog2(NOE + 2),
  localparam int INIT_SELW = (NINIT > 1) ? $clog2(NINIT) : 1
) (
  input  logic                 por_n,
  input  logic [NCLK-1:0]      ext_clk,
  input  logic [NCLK-2:0]      int_clk,
  input  logic [NCLK-2:0]      cfg_clk_int,
  input  logic [CLK_SELW-1:0]  cfg_clk_sel,
  input  logic                 cfg_clk_fall,
  input  logic                 cfg_t_mode,
  input  logic [1:0]           cfg_init_mode,
  input  logic [INIT_SELW-1:0] cfg_init_ct,
  input  logic [NINIT-1:0]     ct_init,
  input  logic [OE_SELW-1:0]   cfg_oe_sel,
  input  logic [NOE-1:0]       ct_oe,
  input  logic                 cfg_gts_en,
  input  logic                 gts_n,
  input  logic                 sum_in,
  input  logic                 pad_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 fb_reg,
  output logic                 fb_pad
);
  logic       cell_clk;
  logic       init_term;
  logic [1:0] init_drv;
  logic       init_set;
  logic       init_clr;
  logic       q;

  mcell_clk_sel #(.NCLK(NCLK)) u_clk (
    .ext_clk_i (ext_clk),
    .int_clk_i (int_clk),
    .use_int_i (cfg_clk_int),
    .sel_i     (cfg_clk_sel),
    .fall_i    (cfg_clk_fall),
    .clk_o     (cell_clk)
  );

  assign init_term = ct_init[cfg_init_ct];
  assign init_drv  = f_init_drive(init_mode_e'(cfg_init_mode), init_term);
  assign init_set  = init_drv[1];
  assign init_clr  = init_drv[0];

  mcell_reg u_reg (
    .clk_i    (cell_clk),
    .por_n_i  (por_n),
    .set_i    (init_set),
    .clr_i    (init_clr),
    .t_mode_i (cfg_t_mode),
    .d_i      (sum_in),
    .q_o      (q)
  );

  mcell_oe #(.NOE(NOE)) u_oe (
    .ct_i     (ct_oe),
    .sel_i    (cfg_oe_sel),
    .gts_en_i (cfg_gts_en),
    .gts_n_i  (gts_n),
    .oe_o     (pad_oe)
  );

  assign pad_out = q;
  assign fb_reg  = q;
  assign fb_pad  = pad_in;

  assert_gts_float_R8: assert property (@(posedge cell_clk) disable iff (!por_n)
    (cfg_gts_en && !gts_n) |-> !pad_oe);

  assert_oe_forced_off_R7: assert property (@(posedge cell_clk) disable iff (!por_n)
    (cfg_oe_sel > OE_SELW'(NOE)) |-> !pad_oe);

  assert_oe_forced_on_R7: assert property (@(posedge cell_clk) disable iff (!por_n)
    (cfg_oe_sel == OE_SELW'(NOE) && !(cfg_gts_en && !gts_n)) |-> pad_oe);

endmodule

// File: tb/mcell_top_bench.sv
module mcell_top_bench;
  logic       clk = 1'b0;
  logic       por_n;
  logic [3:0] ext_clk;
  logic [2:0] int_clk;
  logic [2:0] cfg_clk_int;
  logic [1:0] cfg_clk_sel;
  logic       cfg_clk_fall;
  logic       cfg_t_mode;
  logic [1:0] cfg_init_mode;
  logic       cfg_init_ct;
  logic [1:0] ct_init;
  logic [2:0] cfg_oe_sel;
  logic [3:0] ct_oe;
  logic       cfg_gts_en;
  logic       gts_n;
  logic       sum_in;
  logic       pad_in;
  logic       pad_out;
  logic       pad_oe;
  logic       fb_reg;
  logic       fb_pad;

  int n_chk  = 0;
  int n_fail = 0;
  logic q_m;

  always #4 clk = ~clk;  // 125 MHz

  mcell_top u_mcell_top (
    .por_n(por_n), .ext_clk(ext_clk), .int_clk(int_clk), .cfg_clk_int(cfg_clk_int),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_fall(cfg_clk_fall), .cfg_t_mode(cfg_t_mode),
    .cfg_init_mode(cfg_init_mode), .cfg_init_ct(cfg_init_ct), .ct_init(ct_init),
    .cfg_oe_sel(cfg_oe_sel), .ct_oe(ct_oe), .cfg_gts_en(cfg_gts_en), .gts_n(gts_n),
    .sum_in(sum_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .fb_reg(fb_reg), .fb_pad(fb_pad)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // reference: did the chosen clock source get a pulse
  function automatic bit ref_hit(input logic [3:0] em, input logic [2:0] im);
    if (cfg_clk_sel == 2'd0) return em[0];
    if (cfg_clk_int[cfg_clk_sel - 2'd1]) return im[cfg_clk_sel - 2'd1];
    return em[cfg_clk_sel];
  endfunction

  function automatic logic ref_oe();
    if (cfg_gts_en && !gts_n) return 1'b0;
    if (cfg_oe_sel < 3'd4) return ct_oe[cfg_oe_sel[1:0]];
    return cfg_oe_sel == 3'd4;
  endfunction

  function automatic logic ref_next(input logic q, input logic d);
    return cfg_t_mode ? (q ^ d) : d;
  endfunction

  // 0 none, 1 set, 2 clear
  function automatic int ref_init();
    logic term;
    term = ct_init[cfg_init_ct];
    if (!term) return 0;
    if (cfg_init_mode == 2'b01) return 1;
    if (cfg_init_mode == 2'b10) return 2;
    return 0;
  endfunction

  task automatic check_all(input string req);
    chk(req, "pad_out", pad_out, q_m);
    chk("R9", "fb_reg", fb_reg, q_m);
    chk("R9", "fb_pad", fb_pad, pad_in);
    chk((cfg_gts_en && !gts_n) ? "R8" : "R7", "pad_oe", pad_oe, ref_oe());
  endtask

  task automatic apply_cfg(input logic [1:0] sel, input logic [2:0] ui, input logic fall,
                           input logic t, input logic [1:0] im, input logic ic,
                           input logic [2:0] oes, input logic gen);
    @(negedge clk);
    ct_init = 2'b00;
    por_n = 1'b0;
    #1;
    chk("R1", "por clear", fb_reg, 1'b0);
    cfg_clk_sel = sel; cfg_clk_int = ui; cfg_clk_fall = fall; cfg_t_mode = t;
    cfg_init_mode = im; cfg_init_ct = ic; cfg_oe_sel = oes; cfg_gts_en = gen;
    ext_clk = 4'h0; int_clk = 3'h0;
    #1;
    por_n = 1'b1;
    q_m = 1'b0;
  endtask

  task automatic step(input bit allow_init);
    logic [3:0] em;
    logic [2:0] im;
    int   ini;
    bit   hit;
    string tag;
    @(negedge clk);
    sum_in = 1'($urandom); ct_oe = 4'($urandom); gts_n = 1'($urandom);
    pad_in = 1'($urandom);
    ct_init = allow_init ? 2'($urandom) : 2'b00;
    ini = ref_init();
    if (ini == 1) q_m = 1'b1;
    if (ini == 2) q_m = 1'b0;
    #2;
    check_all((ini != 0) ? "R6" : "R9");
    em = 4'($urandom); im = 3'($urandom);
    hit = ref_hit(em, im);
    tag = (ini != 0) ? "R6" : (cfg_t_mode ? "R3,R4,R5" : "R2,R4,R5");
    @(negedge clk);
    ext_clk = em; int_clk = im;
    #2;
    if (hit && !cfg_clk_fall && ini == 0) q_m = ref_next(q_m, sum_in);
    chk(tag, "after first half", fb_reg, q_m);
    @(negedge clk);
    ext_clk = 4'h0; int_clk = 3'h0;
    #2;
    if (hit && cfg_clk_fall && ini == 0) q_m = ref_next(q_m, sum_in);
    chk(tag, "after second half", fb_reg, q_m);
    @(negedge clk);
    ct_init = 2'b00;
    #2;
    chk("R6", "hold after term release", fb_reg, q_m);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    por_n = 1'b0; ext_clk = 4'h0; int_clk = 3'h0; cfg_clk_int = 3'h0; cfg_clk_sel = 2'd0;
    cfg_clk_fall = 1'b0; cfg_t_mode = 1'b0; cfg_init_mode = 2'b00; cfg_init_ct = 1'b0;
    ct_init = 2'b00; cfg_oe_sel = 3'd4; ct_oe = 4'h0; cfg_gts_en = 1'b0; gts_n = 1'b1;
    sum_in = 1'b0; pad_in = 1'b0; q_m = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset state fb_reg", fb_reg, 1'b0);
    chk("R1", "reset state pad_out", pad_out, 1'b0);

    // every clock number, source kind, polarity and mode (R2..R5)
    for (int s = 0; s < 4; s++)
      for (int u = 0; u < 2; u++)
        for (int f = 0; f < 2; f++)
          for (int t = 0; t < 2; t++) begin
            apply_cfg(2'(s), u ? 3'b111 : 3'b000, 1'(f), 1'(t), 2'b00, 1'b0, 3'd4, 1'b0);
            repeat (6) step(1'b0);
          end

    // initialisation modes and term choice (R6), including the off codes
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int t = 0; t < 2; t++) begin
          apply_cfg(2'($urandom), 3'($urandom), 1'($urandom), 1'(t), 2'(m), 1'(c), 3'd4, 1'b0);
          repeat (8) step(1'b1);
        end

    // output enable sources and global float (R7, R8)
    for (int o = 0; o < 8; o++)
      for (int g = 0; g < 2; g++) begin
        apply_cfg(2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 2'b00, 1'b0,
                  3'(o), 1'(g));
        repeat (5) step(1'b0);
      end

    // random mix
    for (int k = 0; k < 40; k++) begin
      apply_cfg(2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), 3'($urandom), 1'($urandom));
      repeat (6) step(1'b1);
    end

    // directed: power-on reset mid-run beats clocks and set (R1)
    apply_cfg(2'd0, 3'b000, 1'b0, 1'b0, 2'b01, 1'b0, 3'd4, 1'b0);
    @(negedge clk); sum_in = 1'b1;
    @(negedge clk); ext_clk = 4'hF;
    @(negedge clk); ext_clk = 4'h0; #1;
    chk("R2", "directed capture of 1", fb_reg, 1'b1);
    @(negedge clk); por_n = 1'b0; #1;
    chk("R1", "por clears loaded 1", fb_reg, 1'b0);
    @(negedge clk); ext_clk = 4'hF; ct_init = 2'b01;
    @(negedge clk); ext_clk = 4'h0; #1;
    chk("R1", "por beats clock and set", fb_reg, 1'b0);
    ct_init = 2'b00;
    @(negedge clk); por_n = 1'b1;

    summary();
    $finish;
  end

endmodule